// File: doc/BRIEF.md
# Multi-Master I2C Write Controller with Arbitration Loss

This block is an I2C master that writes over an open-drain two-wire bus that other masters may share. A transfer is opened by handing the block a first byte, which holds a 7-bit target address and a direction bit. The block then generates a start condition and shifts that byte out most significant bit first, and checks the acknowledge on the ninth clock. Each later byte is offered through the same valid/ready handshake. SCL is held low while the block waits for the next byte. A byte flagged as last ends the transfer with a stop condition.

SCL and SDA are never driven high. The block only pulls a line low or releases it, and both lines come back through synchronizers. When the block releases SDA for a one bit and reads it back low while SCL is high, another master has won the bus. The block then lets go of both lines at once, raises a sticky loss flag, and accepts no new command until it has seen the other master's stop. A no-acknowledge sets a nack flag and closes the transfer with a stop. A bus monitor tracks start and stop conditions from any master, so a transfer never starts while the bus is in use.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both line drivers are released, `cmd_ready` is 1, and `done`, `nack`, `arb_lost` and `bus_busy` are 0. Accepting a first byte produces exactly one start condition (SDA falling while SCL is high) before the first data clock.
- R2: Each byte appears on the bus MSB first, one bit per SCL pulse. The bus level at the SCL rising edge equals the bit sent. While a byte is being shifted, SDA changes only while SCL is low.
- R3: On the ninth clock the block releases SDA. A low level there (acknowledge) on a byte not marked last makes `cmd_ready` go to 1, and SCL stays low until the next byte is accepted.
- R4: A high level on the ninth clock (no acknowledge) sets `nack` to 1, abandons any remaining bytes and ends the transfer with a stop. `nack` stays 1 until the next command is accepted.
- R5: After the acknowledged last byte, the block produces one stop condition (SDA rising while SCL is high), then a one-cycle `done` pulse, with `bus_busy` already 0.
- R6: While the block drives SCL, each high interval and each low interval of a data clock lasts exactly 2*QUARTER system clocks.
- R7: Another master that sends the same bits at the same time does not cause a loss. Comparison continues bit by bit and the transfer completes with `arb_lost` 0.
- R8: When a released data bit is sampled low, the block releases SCL and SDA on the same clock edge that raises `arb_lost`. `arb_lost` stays 1 until the next command is accepted.
- R9: `bus_busy` is 1 from any observed start to the next observed stop. While it is 1 an idle block holds `cmd_ready` at 0 and drives neither line.
- R10: After a loss the block drives no line and refuses commands until the other master's stop has been seen. A command offered after that runs as a normal transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A byte is offered |
| cmd_ready | output | 1 | Block accepts the offered byte this cycle |
| cmd_data | input | BYTE_W | Byte to send; the first of a transfer is address plus direction bit |
| cmd_last | input | 1 | Offered byte is the final one of the transfer |
| scl_i | input | 1 | Sensed SCL bus level |
| sda_i | input | 1 | Sensed SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| done | output | 1 | One-cycle pulse when a transfer ends with a stop |
| nack | output | 1 | Last transfer ended on a missing acknowledge |
| arb_lost | output | 1 | Sticky: bus lost to another master |
| bus_busy | output | 1 | A start has been seen with no stop since |

## Verification
A shifter or bit counter that goes out of step shows up at the ports within one byte. The bus then carries a different value from the one offered, or the acknowledge clock falls on the wrong pulse. The slave model would then drive an acknowledge into a data bit. A wrong phase count shows as a stretched SCL high or low interval on the very next clock. A wrong loss decision is visible within one bit: either the lines are still driven while another master's zero shows on SDA, or the flag rises while both masters agree. A wrong busy state shows as `cmd_ready` high, or line activity, during a foreign transfer.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BIT,
    S_WAITB,
    S_STOP,
    S_LOST
  } mst_state_t;

  typedef enum logic [1:0] {
    PH_LOW   = 2'd0,
    PH_RISE  = 2'd1,
    PH_HIGH  = 2'd2,
    PH_FALL  = 2'd3
  } bit_phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= 1'b1;
        else     pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2c_phase_gen.sv
module i2c_phase_gen #(
  parameter int QUARTER = 8,
  localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic       tick,
  output logic [1:0] phase
);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(QUARTER - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      phase <= 2'd0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase + 2'd1;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R6: the quarter counter never passes its terminal count
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (32'(cnt) < QUARTER));
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy
);
  logic prev_scl, prev_sda;
  logic start_det, stop_det;

  assign start_det = scl_s && prev_scl && prev_sda && !sda_s;
  assign stop_det  = scl_s && prev_scl && !prev_sda && sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_scl <= 1'b1;
      prev_sda <= 1'b1;
      busy     <= 1'b0;
    end else begin
      prev_scl <= scl_s;
      prev_sda <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  // R9: busy follows observed bus conditions
  assert_busy_on_start_R9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
  assert_free_on_stop_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master #(
  parameter int QUARTER     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  localparam int BI_W       = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cmd_last,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic              nack,
  output logic              arb_lost,
  output logic              bus_busy
);
  import i2c_arb_pkg::*;

  mst_state_t        state;
  logic [BYTE_W-1:0] sreg;
  logic              last_q;
  logic [BI_W-1:0]   bit_idx;
  logic              ack_q;
  logic              scl_s, sda_s;
  logic              tick;
  logic [1:0]        phase;
  logic              run;
  logic              accept;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s));

  i2c_bus_watch u_watch (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .busy(bus_busy));

  assign run = (state == S_START) || (state == S_BIT) || (state == S_STOP);

  i2c_phase_gen #(.QUARTER(QUARTER)) u_phase (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .phase(phase));

  assign cmd_ready = ((state == S_IDLE) && !bus_busy) || (state == S_WAITB);
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      sreg     <= '0;
      last_q   <= 1'b0;
      bit_idx  <= '0;
      ack_q    <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      done     <= 1'b0;
      nack     <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            sreg     <= cmd_data;
            last_q   <= cmd_last;
            nack     <= 1'b0;
            arb_lost <= 1'b0;
            state    <= S_START;
          end
        end
        S_START: begin
          if (tick) begin
            case (phase)
              PH_LOW:  sda_oe <= 1'b1;
              PH_HIGH: scl_oe <= 1'b1;
              PH_FALL: begin
                state   <= S_BIT;
                bit_idx <= '0;
                sda_oe  <= !sreg[BYTE_W-1];
              end
              default: ;
            endcase
          end
        end
        S_BIT: begin
          if (tick) begin
            case (phase)
              PH_LOW: scl_oe <= 1'b0;
              PH_HIGH: begin
                if (bit_idx == BI_W'(BYTE_W)) begin
                  ack_q  <= sda_s;
                  scl_oe <= 1'b1;
                end else if (!sda_oe && !sda_s) begin
                  state    <= S_LOST;
                  scl_oe   <= 1'b0;
                  sda_oe   <= 1'b0;
                  arb_lost <= 1'b1;
                end else begin
                  scl_oe <= 1'b1;
                end
              end
              PH_FALL: begin
                if (bit_idx < BI_W'(BYTE_W - 1)) begin
                  sreg    <= {sreg[BYTE_W-2:0], 1'b0};
                  bit_idx <= bit_idx + 1'b1;
                  sda_oe  <= !sreg[BYTE_W-2];
                end else if (bit_idx == BI_W'(BYTE_W - 1)) begin
                  bit_idx <= bit_idx + 1'b1;
                  sda_oe  <= 1'b0;
                end else if (ack_q) begin
                  nack   <= 1'b1;
                  sda_oe <= 1'b1;
                  state  <= S_STOP;
                end else if (last_q) begin
                  sda_oe <= 1'b1;
                  state  <= S_STOP;
                end else begin
                  state <= S_WAITB;
                end
              end
              default: ;
            endcase
          end
        end
        S_WAITB: begin
          if (accept) begin
            sreg    <= cmd_data;
            last_q  <= cmd_last;
            bit_idx <= '0;
            sda_oe  <= !cmd_data[BYTE_W-1];
            state   <= S_BIT;
          end
        end
        S_STOP: begin
          if (tick) begin
            case (phase)
              PH_LOW:  scl_oe <= 1'b0;
              PH_RISE: sda_oe <= 1'b0;
              PH_FALL: begin
                done  <= 1'b1;
                state <= S_IDLE;
              end
              default: ;
            endcase
          end
        end
        S_LOST: begin
          if (!bus_busy) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: within a byte, SDA moves only while this block holds SCL low
  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_BIT && $past(state) == S_BIT && $changed(sda_oe)) |-> $past(scl_oe));

  // R8: both lines are released when the loss flag rises
  assert_release_on_loss_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe));

  // R10: while deferring, no drive and no command intake
  assert_defer_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOST) |-> (!scl_oe && !sda_oe && !cmd_ready));

  // R5: completion is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: a raised nack only appears with a transfer heading to stop
  assert_nack_stops_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(nack) |-> (state == S_STOP && sda_oe && scl_oe));
endmodule

// File: tb/sim_i2c_arb_master.sv
module sim_i2c_arb_master;
  localparam int Q = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst;
  logic       cmd_valid, cmd_ready, cmd_last;
  logic [7:0] cmd_data;
  logic       scl_oe, sda_oe, done, nack, arb_lost, bus_busy;
  logic       comp_scl_low, comp_man_sda, comp_active, comp_bit_low, slv_low;
  logic       scl_bus, sda_bus;
  logic [7:0] comp_byte;
  int         nack_at;

  assign scl_bus = ~(scl_oe | comp_scl_low);
  assign sda_bus = ~(sda_oe | comp_man_sda | (comp_active & comp_bit_low) | slv_low);

  i2c_arb_master #(.QUARTER(Q), .SYNC_STAGES(2), .BYTE_W(8)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .nack(nack),
    .arb_lost(arb_lost), .bus_busy(bus_busy));

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bus monitor, slave responder, competing-master bit source, scoreboard sink
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  int bitc = 0, byte_idx = 0, start_cnt = 0, stop_cnt = 0;
  int hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;
  logic [7:0] shreg = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
        start_cnt++; bitc = 0; byte_idx = 0;
      end
      if (prev_scl && scl_bus && !prev_sda && sda_bus) stop_cnt++;
      if (!prev_scl && scl_bus) begin
        last_lo = lo_cnt; hi_cnt = 0;
        if (bitc < 8) begin
          shreg = {shreg[6:0], sda_bus};
          bitc++;
          if (bitc == 8) begin
            if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected byte", shreg, -1);
            else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              chk(shreg == e, "R2", "byte on bus", shreg, e);
            end
          end
        end else begin
          bitc = 0; byte_idx++;
        end
      end
      if (prev_scl && !scl_bus) begin
        last_hi = hi_cnt; lo_cnt = 0;
        slv_low = (bitc == 8) && (byte_idx != nack_at);
        comp_bit_low = (byte_idx == 0 && bitc < 8) ? !comp_byte[7 - bitc] : 1'b0;
      end
      if (scl_bus) hi_cnt++; else lo_cnt++;
      prev_scl = scl_bus;
      prev_sda = sda_bus;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // driver: offers bytes, pushes expected bytes into the scoreboard queue
  task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input int n, input int gap, input bit exp_nack, input string req);
    logic [7:0] arr[3];
    bit ended;
    int s0, st0;
    arr = '{b0, b1, b2};
    ended = 0;
    s0 = stop_cnt;
    st0 = start_cnt;
    for (int i = 0; i < n && !ended; i++) begin
      while (!cmd_ready && !done) @(negedge clk);
      if (done) ended = 1;
      else begin
        if (i > 0 && gap > 0) begin
          bit held;
          held = 1;
          for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (scl_bus !== 1'b0 || cmd_ready !== 1'b1) held = 0;
          end
          chk(held, "R3", "SCL low and ready while waiting for next byte", held, 1);
        end
        exp_q.push_back(arr[i]);
        cmd_valid = 1'b1; cmd_data = arr[i]; cmd_last = (i == n - 1);
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    end
    if (!ended) while (!done) @(negedge clk);
    chk(nack == exp_nack, req, "nack flag at done", nack, exp_nack);
    chk(bus_busy == 1'b0, "R5", "bus free at done", bus_busy, 0);
    chk(stop_cnt == s0 + 1, "R5", "stop conditions per transfer", stop_cnt - s0, 1);
    chk(start_cnt == st0 + 1, "R1", "start conditions per transfer", start_cnt - st0, 1);
    chk(exp_q.size() == 0, "R2", "bytes still expected", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R5", "done lasts one cycle", done, 0);
  endtask

  initial begin
    bit quiet;
    rst = 1'b1; cmd_valid = 1'b0; cmd_data = '0; cmd_last = 1'b0;
    comp_scl_low = 1'b0; comp_man_sda = 1'b0; comp_active = 1'b0;
    comp_bit_low = 1'b0; slv_low = 1'b0; comp_byte = '0; nack_at = -1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1", "lines released after reset", {scl_oe, sda_oe}, 0);
    chk(cmd_ready == 1, "R1", "ready after reset", cmd_ready, 1);
    chk({done, nack, arb_lost, bus_busy} == 4'b0, "R1", "flags after reset",
        {done, nack, arb_lost, bus_busy}, 0);

    // plain two-byte write; clock timing
    xfer(8'hA4, 8'h5C, 8'h00, 2, 0, 1'b0, "R3");
    chk(last_hi == 2 * Q, "R6", "SCL high length", last_hi, 2 * Q);
    chk(last_lo == 2 * Q, "R6", "SCL low length", last_lo, 2 * Q);

    // three bytes with a pause between offers
    xfer(8'h3C, 8'hFF, 8'h00, 3, 25, 1'b0, "R3");

    // no acknowledge on second byte of three
    nack_at = 1;
    xfer(8'h50, 8'h81, 8'h7E, 3, 0, 1'b1, "R4");
    // no acknowledge on the address
    nack_at = 0;
    xfer(8'hC3, 8'h11, 8'h00, 2, 0, 1'b1, "R4");
    nack_at = -1;
    chk(nack == 1, "R4", "nack held until next command", nack, 1);

    // identical competitor: no loss
    comp_byte = 8'h6A; comp_active = 1'b1;
    xfer(8'h6A, 8'h99, 8'h00, 2, 0, 1'b0, "R7");
    chk(arb_lost == 0, "R7", "no loss on matching bits", arb_lost, 0);
    comp_active = 1'b0;

    // competitor wins at third bit: B2 vs 92
    comp_byte = 8'h92; comp_active = 1'b1;
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_data = 8'hB2; cmd_last = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!arb_lost) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R8", "lines released with loss flag", {scl_oe, sda_oe}, 0);
    chk(bitc == 3, "R7", "loss on first differing bit", bitc, 3);
    comp_man_sda = 1'b1; comp_active = 1'b0;
    quiet = 1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (scl_oe || sda_oe || cmd_ready) quiet = 0;
    end
    chk(quiet, "R10", "deferring while other master owns bus", quiet, 1);
    chk(bus_busy == 1, "R9", "busy during foreign transfer", bus_busy, 1);
    comp_scl_low = 1'b1; repeat (2 * Q) @(negedge clk);
    comp_scl_low = 1'b0; repeat (2 * Q) @(negedge clk);
    comp_man_sda = 1'b0; repeat (6) @(negedge clk);
    chk(bus_busy == 0, "R9", "free after foreign stop", bus_busy, 0);
    chk(cmd_ready == 1, "R10", "ready after foreign stop", cmd_ready, 1);
    chk(arb_lost == 1, "R8", "loss flag sticky", arb_lost, 1);
    xfer(8'hB2, 8'h40, 8'h00, 2, 0, 1'b0, "R10");
    chk(arb_lost == 0, "R8", "loss flag cleared by new command", arb_lost, 0);

    // foreign start holds off a pending command
    comp_man_sda = 1'b1;
    repeat (6) @(negedge clk);
    chk(bus_busy == 1, "R9", "busy after foreign start", bus_busy, 1);
    exp_q.push_back(8'h2D);
    cmd_valid = 1'b1; cmd_data = 8'h2D; cmd_last = 1'b1;
    quiet = 1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (cmd_ready || scl_oe || sda_oe) quiet = 0;
    end
    chk(quiet, "R9", "no transfer while bus busy", quiet, 1);
    comp_man_sda = 1'b0;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(nack == 0, "R9", "held command completes", nack, 0);
    chk(exp_q.size() == 0, "R2", "held byte seen on bus", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule